// File: doc/BRIEF.md
# Three-Stage Decimating Low-Pass Chain

This block takes one channel of signed mixer output at the full input rate, applies three low-pass filter stages in cascade, and drops the sample rate after each stage. The total rate reduction is 800, so a 20 MS/s input comes out at 25 kS/s. The first two stages are short, 3 taps each. They cut the rate by 20 and then by 10. Because of this, the sharp 17-tap stage at the end only runs at the low rate and then divides by 4. An I/Q pair uses two instances that share one coefficient set.

Each stage computes only the outputs that survive decimation. The two 3-tap stages evaluate their products in the single cycle that an output is due. The 17-tap stage reuses one multiplier over 17 consecutive clocks. Coefficients are signed Q1.15 values, written one per cycle through a write port. A synchronous flush clears the filter history, the phase counters and any result still being computed. It keeps the coefficients.

Top module: `tri_decim_lpf`

## Requirements
- R1: During reset and after reset, outValid is 0 and outData is 0. No output appears until 800 valid inputs have been accepted.
- R2: Exactly one output pulse is produced for each 800 accepted inputs. It belongs to the 800th, 1600th, ... input counted from reset or flush, and no pulse occurs at any other time.
- R3: Stage A keeps the newest 3 inputs (tap 0 = newest). On every 20th input it produces round(sum(cA[k]·x[n-k]) / 2^15).
- R4: Stage B does the same over the newest 3 stage A outputs with coefficients cB, on every 10th stage A output.
- R5: Stage C does the same over the newest 17 stage B outputs with coefficients cC, on every 4th stage B output. Its result is the value on outData.
- R6: Each stage rounds half toward +infinity. It then saturates to the data range [-2^(DW-1), 2^(DW-1)-1] before passing the value on. No overflow can occur inside the accumulators.
- R7: A write with coefWe=1 stores coefData into the coefficient at coefAddr: 0..2 = cA[0..2], 3..5 = cB[0..2], 6..22 = cC[0..16]. Writes to addresses 23..31 have no effect on any output.
- R8: A one-cycle flush empties all three histories and all phase counters, cancels a result in flight and sets outData to 0. The coefficients are kept.
- R9: Cycles with inValid=0 have no effect, whatever the value on inData.
- R10: outValid is a one-cycle pulse. It is high in the cycle after the 19th clock edge following the edge that accepts the completing input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, also clears coefficients |
| flush | input | 1 | Synchronous clear of histories, counters and in-flight result |
| inValid | input | 1 | Input sample strobe |
| inData | input | DW | Signed input sample |
| coefWe | input | 1 | Coefficient write enable |
| coefAddr | input | 5 | Coefficient index |
| coefData | input | CW | Signed Q1.15 coefficient |
| outValid | output | 1 | Output sample strobe |
| outData | output | DW | Signed filtered, decimated sample |

## Verification
The chain is driven with full-range random samples, using random coefficients in every stage. This is done twice: once with random idle gaps and junk on inData while inValid is low, and once with a strobe in every cycle. The gapped run separates counting by accepted samples from counting by clocks. The back-to-back run exposes any loss when the serial stage overlaps incoming data. Constant full-scale positive and negative inputs with all coefficients at the maximum force saturation in every stage. A directed ±3 input with a half coefficient tells the half-up rounding apart from truncation and from symmetric rounding. A flush issued part-way through a decimation period is followed by exactly 799 and then one more sample, which shows that the phase counters really restart.

// File: rtl/tdl_pkg.sv
`timescale 1ns/1ps
package tdl_pkg;
  localparam int DATA_W  = 12;
  localparam int COEF_W  = 16;
  localparam int CADDR_W = 5;

  localparam int TAPS1  = 3;
  localparam int RATIO1 = 20;
  localparam int TAPS2  = 3;
  localparam int RATIO2 = 10;
  localparam int TAPS3  = 17;
  localparam int RATIO3 = 4;

  localparam int BASE2 = TAPS1;
  localparam int BASE3 = TAPS1 + TAPS2;
  localparam int TOTAL_RATIO = RATIO1 * RATIO2 * RATIO3;
  localparam int LATENCY = TAPS3 + 2;

  localparam int PH1_W = $clog2(RATIO1);
  localparam int PH2_W = $clog2(RATIO2);
  localparam int PH3_W = $clog2(RATIO3);
  localparam int IDX_W = $clog2(TAPS3);

  typedef struct packed {
    logic shift1;
    logic emit1;
    logic shift2;
    logic emit2;
    logic shift3;
    logic macStart;
    logic macStep;
    logic macLast;
    logic [IDX_W-1:0] macIdx;
  } tdl_strobe_t;
endpackage

// File: rtl/tdl_round_sat.sv
`timescale 1ns/1ps
module tdl_round_sat #(
  parameter int AW   = 32,
  parameter int DW   = 12,
  parameter int FRAC = 15
) (
  input  logic signed [AW-1:0] accIn,
  output logic signed [DW-1:0] sampleOut
);
  localparam logic signed [AW:0] HALF = (AW+1)'(1) << (FRAC-1);
  localparam logic signed [AW:0] MAXV = (AW+1)'((2**(DW-1)) - 1);
  localparam logic signed [AW:0] MINV = ~MAXV;

  logic signed [AW:0] biased;
  logic signed [AW:0] scaled;

  always_comb begin
    biased = {accIn[AW-1], accIn} + HALF;
    scaled = biased >>> FRAC;
    if (scaled > MAXV)
      sampleOut = MAXV[DW-1:0];
    else if (scaled < MINV)
      sampleOut = MINV[DW-1:0];
    else
      sampleOut = scaled[DW-1:0];
  end
endmodule

// File: rtl/tdl_fir_direct.sv
`timescale 1ns/1ps
module tdl_fir_direct #(
  parameter int TAPS = 3,
  parameter int DW   = 12,
  parameter int CW   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     shift,
  input  logic                     emit,
  input  logic signed [DW-1:0]     sampleIn,
  input  logic [TAPS-1:0][CW-1:0]  coefs,
  output logic signed [DW-1:0]     yOut
);
  localparam int PW = DW + CW;
  localparam int AW = PW + $clog2(TAPS);

  logic signed [DW-1:0] hist [TAPS-1];
  logic signed [DW-1:0] win  [TAPS];
  logic signed [PW-1:0] prod [TAPS];
  logic signed [AW-1:0] acc;
  logic signed [DW-1:0] rounded;

  always_comb begin
    win[0] = sampleIn;
    for (int k = 1; k < TAPS; k++) win[k] = hist[k-1];
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) begin
      prod[k] = $signed(coefs[k]) * win[k];
      acc = acc + AW'(prod[k]);
    end
  end

  tdl_round_sat #(.AW(AW), .DW(DW), .FRAC(CW-1)) u_rs (
    .accIn(acc),
    .sampleOut(rounded)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int k = 0; k < TAPS-1; k++) hist[k] <= '0;
      yOut <= '0;
    end else begin
      if (shift) begin
        hist[0] <= sampleIn;
        for (int k = 1; k < TAPS-1; k++) hist[k] <= hist[k-1];
      end
      if (emit) yOut <= rounded;
    end
  end
endmodule

// File: rtl/tdl_ctrl.sv
`timescale 1ns/1ps
module tdl_ctrl
  import tdl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        flush,
  input  logic        inValid,
  output tdl_strobe_t strobes,
  output logic        outValid
);
  logic [PH1_W-1:0] ph1;
  logic [PH2_W-1:0] ph2;
  logic [PH3_W-1:0] ph3;
  logic [IDX_W-1:0] idx;
  logic             busy;
  logic             v1;
  logic             v2;

  always_comb begin
    strobes.shift1   = inValid;
    strobes.emit1    = inValid && (ph1 == PH1_W'(RATIO1-1));
    strobes.shift2   = v1;
    strobes.emit2    = v1 && (ph2 == PH2_W'(RATIO2-1));
    strobes.shift3   = v2;
    strobes.macStart = v2 && (ph3 == PH3_W'(RATIO3-1));
    strobes.macStep  = busy;
    strobes.macLast  = busy && (idx == IDX_W'(TAPS3-1));
    strobes.macIdx   = idx;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ph1 <= '0; ph2 <= '0; ph3 <= '0;
      idx <= '0; busy <= 1'b0;
      v1 <= 1'b0; v2 <= 1'b0; outValid <= 1'b0;
    end else begin
      if (strobes.shift1) ph1 <= strobes.emit1 ? '0 : ph1 + 1'b1;
      if (strobes.shift2) ph2 <= strobes.emit2 ? '0 : ph2 + 1'b1;
      if (strobes.shift3) ph3 <= strobes.macStart ? '0 : ph3 + 1'b1;
      v1 <= strobes.emit1;
      v2 <= strobes.emit2;
      outValid <= strobes.macLast;
      if (strobes.macStart) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (strobes.macLast) begin
        busy <= 1'b0;
        idx  <= '0;
      end else if (busy) begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdl_datapath.sv
`timescale 1ns/1ps
module tdl_datapath
  import tdl_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int CW  = COEF_W,
  parameter int CAW = CADDR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  tdl_strobe_t          strobes,
  input  logic signed [DW-1:0] inData,
  input  logic                 coefWe,
  input  logic [CAW-1:0]       coefAddr,
  input  logic [CW-1:0]        coefData,
  output logic signed [DW-1:0] outData
);
  localparam int PW  = DW + CW;
  localparam int AW3 = PW + $clog2(TAPS3);

  logic [TAPS1-1:0][CW-1:0] coef1;
  logic [TAPS2-1:0][CW-1:0] coef2;
  logic signed [CW-1:0]     coef3 [TAPS3];

  logic signed [DW-1:0]  y1;
  logic signed [DW-1:0]  y2;
  logic signed [DW-1:0]  hist3 [TAPS3];
  logic signed [PW-1:0]  prod3;
  logic signed [AW3-1:0] acc3;
  logic signed [AW3-1:0] sum3;
  logic signed [DW-1:0]  rounded3;

  always_ff @(posedge clk) begin
    if (rst) begin
      coef1 <= '0;
      coef2 <= '0;
      for (int k = 0; k < TAPS3; k++) coef3[k] <= '0;
    end else if (coefWe) begin
      for (int k = 0; k < TAPS1; k++)
        if (coefAddr == CAW'(k)) coef1[k] <= coefData;
      for (int k = 0; k < TAPS2; k++)
        if (coefAddr == CAW'(BASE2 + k)) coef2[k] <= coefData;
      for (int k = 0; k < TAPS3; k++)
        if (coefAddr == CAW'(BASE3 + k)) coef3[k] <= coefData;
    end
  end

  tdl_fir_direct #(.TAPS(TAPS1), .DW(DW), .CW(CW)) u_stageA (
    .clk(clk), .rst(rst), .clr(flush),
    .shift(strobes.shift1), .emit(strobes.emit1),
    .sampleIn(inData), .coefs(coef1), .yOut(y1)
  );

  tdl_fir_direct #(.TAPS(TAPS2), .DW(DW), .CW(CW)) u_stageB (
    .clk(clk), .rst(rst), .clr(flush),
    .shift(strobes.shift2), .emit(strobes.emit2),
    .sampleIn(y1), .coefs(coef2), .yOut(y2)
  );

  always_comb begin
    prod3 = coef3[strobes.macIdx] * hist3[strobes.macIdx];
    sum3  = acc3 + AW3'(prod3);
  end

  tdl_round_sat #(.AW(AW3), .DW(DW), .FRAC(CW-1)) u_rs3 (
    .accIn(sum3),
    .sampleOut(rounded3)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int k = 0; k < TAPS3; k++) hist3[k] <= '0;
      acc3    <= '0;
      outData <= '0;
    end else begin
      if (strobes.shift3) begin
        hist3[0] <= y2;
        for (int k = 1; k < TAPS3; k++) hist3[k] <= hist3[k-1];
      end
      if (strobes.macStart) acc3 <= '0;
      else if (strobes.macStep) acc3 <= sum3;
      if (strobes.macLast) outData <= rounded3;
    end
  end
endmodule

// File: rtl/tri_decim_lpf.sv
`timescale 1ns/1ps
module tri_decim_lpf
  import tdl_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int CW  = COEF_W,
  parameter int CAW = CADDR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 inValid,
  input  logic signed [DW-1:0] inData,
  input  logic                 coefWe,
  input  logic [CAW-1:0]       coefAddr,
  input  logic [CW-1:0]        coefData,
  output logic                 outValid,
  output logic signed [DW-1:0] outData
);
  tdl_strobe_t strobes;

  tdl_ctrl u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .inValid(inValid),
    .strobes(strobes), .outValid(outValid)
  );

  tdl_datapath #(.DW(DW), .CW(CW), .CAW(CAW)) u_dp (
    .clk(clk), .rst(rst), .flush(flush), .strobes(strobes),
    .inData(inData), .coefWe(coefWe), .coefAddr(coefAddr),
    .coefData(coefData), .outData(outData)
  );
endmodule

// File: rtl/tri_decim_lpf_chk.sv
`timescale 1ns/1ps
module tri_decim_lpf_chk
  import tdl_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic flush,
  input logic inValid,
  input logic outValid,
  input logic macStart,
  input logic macStep
);
  localparam int CNT_W = $clog2(TOTAL_RATIO);
  localparam int TMR_W = $clog2(LATENCY + 1);

  logic [CNT_W-1:0] inCount;
  logic [TMR_W-1:0] dueTimer;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      inCount  <= '0;
      dueTimer <= '0;
    end else begin
      if (inValid && inCount == CNT_W'(TOTAL_RATIO-1)) begin
        inCount  <= '0;
        dueTimer <= TMR_W'(LATENCY);
      end else begin
        if (inValid) inCount <= inCount + 1'b1;
        if (dueTimer != '0) dueTimer <= dueTimer - 1'b1;
      end
    end
  end

  // R10: output strobe lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R8: flush silences the output on the next cycle
  a_r8_flush_quiet: assert property (@(posedge clk) disable iff (rst)
    flush |=> !outValid);

  // R2: a completed 800-sample period yields its pulse on time
  a_r2_out_due: assert property (@(posedge clk) disable iff (rst || flush)
    (dueTimer == TMR_W'(1)) |=> outValid);

  // R2: no pulse without a completed period
  a_r2_no_stray: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ($past(dueTimer) == TMR_W'(1)));

  // R5: the serial stage is never restarted while still accumulating
  a_r5_no_restart: assert property (@(posedge clk) disable iff (rst)
    macStart |-> !macStep);
endmodule

bind tri_decim_lpf tri_decim_lpf_chk u_chk (
  .clk(clk), .rst(rst), .flush(flush), .inValid(inValid),
  .outValid(outValid), .macStart(strobes.macStart), .macStep(strobes.macStep)
);

// File: tb/tri_decim_lpf_test.sv
`timescale 1ns/1ps
module tri_decim_lpf_test;
  localparam int CLK_NS = 8;
  localparam int DW = 12;
  localparam int CW = 16;
  localparam int LAT = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic inValid = 1'b0;
  logic signed [DW-1:0] inData = '0;
  logic coefWe = 1'b0;
  logic [4:0] coefAddr = '0;
  logic [CW-1:0] coefData = '0;
  logic outValid;
  logic signed [DW-1:0] outData;

  tri_decim_lpf uut (
    .clk(clk), .rst(rst), .flush(flush), .inValid(inValid), .inData(inData),
    .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData),
    .outValid(outValid), .outData(outData)
  );

  always #(CLK_NS/2) clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFails = 0;
  int outSeen = 0;
  int lastOut = 0;

  int ka[3], kb[3], kc[17];
  int ha[3], hb[3], hc[17];
  int pa, pb, pc;
  int expVal[$];
  int unsigned expCyc[$];

  function automatic int rndSat(longint a);
    longint b;
    b = (a + 64'sd16384) >>> 15;
    if (b > 2047) return 2047;
    if (b < -2048) return -2048;
    return int'(b);
  endfunction

  function automatic void modelClear();
    for (int i = 0; i < 3; i++) begin ha[i] = 0; hb[i] = 0; end
    for (int i = 0; i < 17; i++) hc[i] = 0;
    pa = 0; pb = 0; pc = 0;
  endfunction

  function automatic void modelPush(int x, int unsigned due);
    longint s;
    ha[2] = ha[1]; ha[1] = ha[0]; ha[0] = x;
    pa++;
    if (pa < 20) return;
    pa = 0;
    s = 0;
    for (int i = 0; i < 3; i++) s += longint'(ka[i]) * ha[i];
    hb[2] = hb[1]; hb[1] = hb[0]; hb[0] = rndSat(s);
    pb++;
    if (pb < 10) return;
    pb = 0;
    s = 0;
    for (int i = 0; i < 3; i++) s += longint'(kb[i]) * hb[i];
    for (int i = 16; i > 0; i--) hc[i] = hc[i-1];
    hc[0] = rndSat(s);
    pc++;
    if (pc < 4) return;
    pc = 0;
    s = 0;
    for (int i = 0; i < 17; i++) s += longint'(kc[i]) * hc[i];
    expVal.push_back(rndSat(s));
    expCyc.push_back(due);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrCoef(int a, int v);
    @(negedge clk);
    coefWe = 1'b1; coefAddr = 5'(a); coefData = CW'(v);
    if (a < 3) ka[a] = v;
    else if (a < 6) kb[a-3] = v;
    else if (a < 23) kc[a-6] = v;
    @(negedge clk);
    coefWe = 1'b0;
  endtask

  task automatic feed(int n, int gapPct, bit useConst, int cval);
    int x;
    for (int i = 0; i < n; i++) begin
      while (int'($urandom_range(99)) < gapPct) begin
        @(negedge clk);
        inValid = 1'b0;
        inData = DW'($urandom);
      end
      @(negedge clk);
      x = useConst ? cval : (int'($urandom_range(4095)) - 2048);
      inValid = 1'b1;
      inData = DW'(x);
      modelPush(x, cyc + LAT);
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    modelClear();
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (!rst && outValid === 1'b1) begin
      outSeen++;
      lastOut = int'(outData);
      if (expVal.size() == 0) begin
        check(1'b0, "R2 unexpected output pulse", int'(outData), 0);
      end else begin
        int ev;
        int unsigned ec;
        ev = expVal.pop_front();
        ec = expCyc.pop_front();
        check(int'(outData) == ev, "R3/R4/R5 output value", int'(outData), ev);
        check(cyc == ec, "R10 output latency (cycle)", int'(cyc), int'(ec));
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    int seen;
    void'($urandom(32'd4242));
    modelClear();
    for (int i = 0; i < 17; i++) kc[i] = 0;
    for (int i = 0; i < 3; i++) begin ka[i] = 0; kb[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0, "R1 outValid in reset", int'(outValid), 0);
    check(outData == '0, "R1 outData in reset", int'(outData), 0);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);

    // R7: random coefficients per stage, then junk at unused addresses
    for (int a = 0; a < 23; a++) wrCoef(a, int'($urandom_range(16000)) - 8000);
    for (int a = 23; a < 32; a++) wrCoef(a, int'($urandom_range(65535)) - 32768);

    // R3 R4 R5 R9: gapped random stream with junk while idle
    feed(8000, 25, 1'b0, 0);
    repeat (40) @(negedge clk);
    check(outSeen == 10, "R2 pulses for 8000 gapped inputs", outSeen, 10);

    // R2 R5: back-to-back stream
    feed(4000, 0, 1'b0, 0);
    repeat (40) @(negedge clk);
    check(outSeen == 15, "R2 pulses after back-to-back run", outSeen, 15);

    // R8: flush mid-period, then exactly 799 samples give nothing
    feed(300, 10, 1'b0, 0);
    repeat (5) @(negedge clk);
    doFlush();
    check(outData == '0, "R8 outData cleared by flush", int'(outData), 0);
    seen = outSeen;
    feed(799, 0, 1'b0, 0);
    repeat (40) @(negedge clk);
    check(outSeen == seen, "R8 no pulse before 800th after flush", outSeen, seen);
    feed(1, 0, 1'b0, 0);
    repeat (40) @(negedge clk);
    check(outSeen == seen + 1, "R2 pulse on 800th after flush", outSeen, seen + 1);

    // R6: saturation with full-scale coefficients
    for (int a = 0; a < 23; a++) wrCoef(a, 32767);
    doFlush();
    feed(800, 0, 1'b1, 2047);
    repeat (40) @(negedge clk);
    check(lastOut == 2047, "R6 positive saturation", lastOut, 2047);
    feed(1600, 5, 1'b1, -2048);
    repeat (40) @(negedge clk);
    check(lastOut == -2048, "R6 negative saturation", lastOut, -2048);

    // R6: half-up rounding (0.5 * 3 -> 2, 0.5 * -3 -> -1)
    for (int a = 0; a < 23; a++) wrCoef(a, 0);
    wrCoef(0, 16384);
    wrCoef(3, 32767);
    wrCoef(6, 32767);
    doFlush();
    feed(800, 0, 1'b1, 3);
    repeat (40) @(negedge clk);
    check(lastOut == 2, "R6 rounding of +1.5", lastOut, 2);
    doFlush();
    feed(800, 0, 1'b1, -3);
    repeat (40) @(negedge clk);
    check(lastOut == -1, "R6 rounding of -1.5", lastOut, -1);

    check(expVal.size() == 0, "R2 every expected pulse arrived", expVal.size(), 0);
    finishRun();
  end
endmodule